// File: doc/BRIEF.md
# Interpolator Blend and Clamp Unit

This unit is the arithmetic back end that sits beside a pair of interpolator lanes. It holds the two base registers and turns the lanes' shifted-and-masked values into final lane results. In blend mode the lane 1 result becomes a linear mix of the two bases. The mix is weighted by an 8-bit fraction taken from lane 1's shifted-and-masked value. In clamp mode the lane 0 result becomes lane 0's shifted-and-masked value limited to the window whose floor is base 0 and whose ceiling is base 1.

The bases can be loaded one at a time with a full-width word. A single paired write can also load both bases from the two halves of one word. When a mode is off, the ordinary lane result computed upstream passes through unchanged. All results and bases are registered, so each output appears one clock after its inputs.

Top module: `lerp_clamp_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `res0`, `res1`, `base0` and `base1` are all zero.
- R2: With `wr_base0` high at a clock edge, `base0` takes `wdata` after that edge. With `wr_base1` high, `base1` takes `wdata` in the same way.
- R3: With `wr_pair` high at an edge, `base0` takes `wdata[15:0]` and `base1` takes `wdata[31:16]`. Each half is sign-extended when that lane's signed flag (`sgn0` for base 0, `sgn1` for base 1) is high, and zero-extended otherwise. `wr_pair` overrides `wr_base0` and `wr_base1` in the same cycle.
- R4: With `blend_en` high, `res1` becomes base0 + floor((base1 − base0) × f / 256). Here f is `lane1_sm[7:0]`, taken as 0..255, and the upper bits of `lane1_sm` are ignored. The result is truncated to 32 bits.
- R5: During a blend, `sgn1` high treats both bases as two's-complement signed values, and `sgn1` low treats them as unsigned. The floor rounds toward negative infinity.
- R6: With `blend_en` low, `res1` equals `lane1_sum` from the previous cycle.
- R7: With `clamp_en` high, `res0` is computed from v = `lane0_sm` as follows. If v < base0, `res0` is base0. Otherwise, if v > base1, `res0` is base1. Otherwise `res0` is v. The lower-bound test has priority. Both comparisons are signed when `sgn0` is high and unsigned otherwise.
- R8: With `clamp_en` low, `res0` equals `lane0_sum` from the previous cycle, whatever `blend_en` is.
- R9: Results are registered once, and they use the base values held before the same edge. A base write in the same cycle affects results only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_base0 | input | 1 | Load `wdata` into base 0 |
| wr_base1 | input | 1 | Load `wdata` into base 1 |
| wr_pair | input | 1 | Load both bases from the halves of `wdata` |
| wdata | input | 32 | Write data for the bases |
| sgn0 | input | 1 | Lane 0 signed flag (clamp compare, low-half extension) |
| sgn1 | input | 1 | Lane 1 signed flag (blend signedness, high-half extension) |
| blend_en | input | 1 | Blend mode enable (from lane 0 configuration) |
| clamp_en | input | 1 | Clamp mode enable for lane 0 |
| lane0_sm | input | 32 | Lane 0 shifted-and-masked value |
| lane1_sm | input | 32 | Lane 1 shifted-and-masked value |
| lane0_sum | input | 32 | Ordinary lane 0 result |
| lane1_sum | input | 32 | Ordinary lane 1 result |
| res0 | output | 32 | Final lane 0 result |
| res1 | output | 32 | Final lane 1 result |
| base0 | output | 32 | Current base 0 |
| base1 | output | 32 | Current base 1 |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, 16-bit halves for the paired write, and an 8-bit fraction. At this width the tests can reach three cases. The first is the full 33-bit difference of an unsigned blend across the top of the range, which gives exactly 0x80000000. The second is a negative difference whose floor differs from truncation toward zero. The third is a paired write whose halves carry set sign bits. The 8-bit fraction is also small enough to sweep the same points a fixed-point caller would use, from 0 up to 255.

// File: rtl/lerp_clamp_pkg.sv
package lerp_clamp_pkg;

    // Outcome of the window check on lane 0
    typedef enum logic [1:0] {
        CLAMP_PASS  = 2'd0,
        CLAMP_FLOOR = 2'd1,
        CLAMP_CEIL  = 2'd2
    } clamp_sel_e;

    localparam int DEF_DATA_W = 32;
    localparam int DEF_FRAC_W = 8;

endpackage

// File: rtl/lcu_base_bank.sv
module lcu_base_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base0,
    input  logic              wr_base1,
    input  logic              wr_pair,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sgn0,
    input  logic              sgn1,
    output logic [DATA_W-1:0] base0,
    output logic [DATA_W-1:0] base1
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] b0;
        logic [DATA_W-1:0] b1;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [DATA_W-1:0] widen_half(
        input logic [HALF_W-1:0] h,
        input logic              sgn
    );
        widen_half = {{(DATA_W-HALF_W){sgn & h[HALF_W-1]}}, h};
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_pair) begin
            bank_d.b0 = widen_half(wdata[HALF_W-1:0], sgn0);
            bank_d.b1 = widen_half(wdata[2*HALF_W-1:HALF_W], sgn1);
        end else begin
            if (wr_base0) bank_d.b0 = wdata;
            if (wr_base1) bank_d.b1 = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign base0 = bank_q.b0;
    assign base1 = bank_q.b1;
endmodule

// File: rtl/lcu_blend.sv
module lcu_blend #(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 8
) (
    input  logic [DATA_W-1:0] lo_val,
    input  logic [DATA_W-1:0] hi_val,
    input  logic [FRAC_W-1:0] frac,
    input  logic              sgn,
    output logic [DATA_W-1:0] mix
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int PROD_W = EXT_W + FRAC_W + 1;

    logic signed [EXT_W-1:0]  lo_ext, hi_ext, span;
    logic signed [PROD_W-1:0] span_w, frac_w, prod, step;

    always_comb begin
        lo_ext = {sgn & lo_val[DATA_W-1], lo_val};
        hi_ext = {sgn & hi_val[DATA_W-1], hi_val};
        span   = hi_ext - lo_ext;
        span_w = PROD_W'(span);
        frac_w = $signed({{(PROD_W-FRAC_W){1'b0}}, frac});
        prod   = span_w * frac_w;
        step   = prod >>> FRAC_W;
        mix    = lo_val + step[DATA_W-1:0];
    end
endmodule

// File: rtl/lcu_clamp.sv
module lcu_clamp
    import lerp_clamp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] floor_val,
    input  logic [DATA_W-1:0] ceil_val,
    input  logic              sgn,
    output clamp_sel_e        sel,
    output logic [DATA_W-1:0] limited
);
    logic signed [DATA_W:0] v_e, f_e, c_e;

    always_comb begin
        v_e = {sgn & value[DATA_W-1], value};
        f_e = {sgn & floor_val[DATA_W-1], floor_val};
        c_e = {sgn & ceil_val[DATA_W-1], ceil_val};
        if (v_e < f_e)      sel = CLAMP_FLOOR;
        else if (v_e > c_e) sel = CLAMP_CEIL;
        else                sel = CLAMP_PASS;
        case (sel)
            CLAMP_FLOOR: limited = floor_val;
            CLAMP_CEIL:  limited = ceil_val;
            default:     limited = value;
        endcase
    end
endmodule

// File: rtl/lerp_clamp_unit.sv
module lerp_clamp_unit
    import lerp_clamp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base0,
    input  logic              wr_base1,
    input  logic              wr_pair,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sgn0,
    input  logic              sgn1,
    input  logic              blend_en,
    input  logic              clamp_en,
    input  logic [DATA_W-1:0] lane0_sm,
    input  logic [DATA_W-1:0] lane1_sm,
    input  logic [DATA_W-1:0] lane0_sum,
    input  logic [DATA_W-1:0] lane1_sum,
    output logic [DATA_W-1:0] res0,
    output logic [DATA_W-1:0] res1,
    output logic [DATA_W-1:0] base0,
    output logic [DATA_W-1:0] base1
);
    typedef struct packed {
        logic [DATA_W-1:0] r0;
        logic [DATA_W-1:0] r1;
    } out_t;

    out_t out_d, out_q;

    logic [DATA_W-1:0] mix_val, lim_val;
    clamp_sel_e        lim_sel;

    lcu_base_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_base0 (wr_base0),
        .wr_base1 (wr_base1),
        .wr_pair  (wr_pair),
        .wdata    (wdata),
        .sgn0     (sgn0),
        .sgn1     (sgn1),
        .base0    (base0),
        .base1    (base1)
    );

    lcu_blend #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_blend (
        .lo_val (base0),
        .hi_val (base1),
        .frac   (lane1_sm[FRAC_W-1:0]),
        .sgn    (sgn1),
        .mix    (mix_val)
    );

    lcu_clamp #(.DATA_W(DATA_W)) u_clamp (
        .value     (lane0_sm),
        .floor_val (base0),
        .ceil_val  (base1),
        .sgn       (sgn0),
        .sel       (lim_sel),
        .limited   (lim_val)
    );

    always_comb begin
        out_d    = out_q;
        out_d.r0 = clamp_en ? lim_val : lane0_sum;
        out_d.r1 = blend_en ? mix_val : lane1_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res0 = out_q.r0;
    assign res1 = out_q.r1;
endmodule

// File: rtl/lerp_clamp_checker.sv
module lerp_clamp_checker #(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_base0,
    input logic              wr_pair,
    input logic [DATA_W-1:0] wdata,
    input logic              blend_en,
    input logic              clamp_en,
    input logic              sgn0,
    input logic [DATA_W-1:0] lane1_sm,
    input logic [DATA_W-1:0] lane0_sum,
    input logic [DATA_W-1:0] lane1_sum,
    input logic [DATA_W-1:0] res0,
    input logic [DATA_W-1:0] res1,
    input logic [DATA_W-1:0] base0,
    input logic [DATA_W-1:0] base1
);
    localparam int HALF_W = DATA_W / 2;

    // high once a full cycle out of reset has passed, so $past sees live values
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (res0 == '0 && res1 == '0) || !rst_n);

    a_r2_base0_load: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wr_base0 && !wr_pair)) |-> base0 == $past(wdata));

    a_r3_pair_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wr_pair)) |->
            (base0[HALF_W-1:0] == $past(wdata[HALF_W-1:0]) &&
             base1[HALF_W-1:0] == $past(wdata[2*HALF_W-1:HALF_W])));

    a_r4_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(blend_en && lane1_sm[FRAC_W-1:0] == '0)) |-> res1 == $past(base0));

    a_r6_blend_off: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!blend_en)) |-> res1 == $past(lane1_sum));

    a_r7_window_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(clamp_en && !sgn0 && base0 <= base1)) |->
            (res0 >= $past(base0) && res0 <= $past(base1)));

    a_r8_clamp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!clamp_en)) |-> res0 == $past(lane0_sum));
endmodule

bind lerp_clamp_unit lerp_clamp_checker #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_base0  (wr_base0),
    .wr_pair   (wr_pair),
    .wdata     (wdata),
    .blend_en  (blend_en),
    .clamp_en  (clamp_en),
    .sgn0      (sgn0),
    .lane1_sm  (lane1_sm),
    .lane0_sum (lane0_sum),
    .lane1_sum (lane1_sum),
    .res0      (res0),
    .res1      (res1),
    .base0     (base0),
    .base1     (base1)
);

// File: tb/test_lerp_clamp_unit.sv
`timescale 1ns/1ps
module test_lerp_clamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_base0 = 0, wr_base1 = 0, wr_pair = 0;
    logic [31:0] wdata = '0;
    logic        sgn0 = 0, sgn1 = 0, blend_en = 0, clamp_en = 0;
    logic [31:0] lane0_sm = '0, lane1_sm = '0, lane0_sum = '0, lane1_sum = '0;
    logic [31:0] res0, res1, base0, base1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lerp_clamp_unit i_lerp_clamp_unit (
        .clk(clk), .rst_n(rst_n), .wr_base0(wr_base0), .wr_base1(wr_base1),
        .wr_pair(wr_pair), .wdata(wdata), .sgn0(sgn0), .sgn1(sgn1),
        .blend_en(blend_en), .clamp_en(clamp_en), .lane0_sm(lane0_sm),
        .lane1_sm(lane1_sm), .lane0_sum(lane0_sum), .lane1_sum(lane1_sum),
        .res0(res0), .res1(res1), .base0(base0), .base1(base1)
    );

    typedef struct packed {
        logic [31:0] b0;
        logic [31:0] b1;
        logic [7:0]  frac;
        logic        sgn;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'd500, 32'd1000, 8'd0,   1'b0, 32'd500},
        '{32'd500, 32'd1000, 8'd42,  1'b0, 32'd582},
        '{32'd500, 32'd1000, 8'd85,  1'b0, 32'd666},
        '{32'd500, 32'd1000, 8'd127, 1'b0, 32'd748},
        '{32'd500, 32'd1000, 8'd170, 1'b0, 32'd832},
        '{32'd500, 32'd1000, 8'd212, 1'b0, 32'd914},
        '{32'd500, 32'd1000, 8'd255, 1'b0, 32'd998},
        '{32'hFFFFFC18, 32'd1000, 8'd0,   1'b1, 32'hFFFFFC18},
        '{32'hFFFFFC18, 32'd1000, 8'd42,  1'b1, 32'hFFFFFD60},
        '{32'hFFFFFC18, 32'd1000, 8'd85,  1'b1, 32'hFFFFFEB0},
        '{32'hFFFFFC18, 32'd1000, 8'd127, 1'b1, 32'hFFFFFFF8},
        '{32'hFFFFFC18, 32'd1000, 8'd170, 1'b1, 32'd328},
        '{32'hFFFFFC18, 32'd1000, 8'd212, 1'b1, 32'd656},
        '{32'hFFFFFC18, 32'd1000, 8'd255, 1'b1, 32'd992},
        '{32'd1000, 32'hFFFFFC18, 8'd1,   1'b1, 32'd992},
        '{32'hFFFFFC18, 32'd1000, 8'd128, 1'b0, 32'h80000000}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    task automatic set_bases(input logic [31:0] b0, input logic [31:0] b1);
        wr_base0 = 1; wdata = b0; tick();
        wr_base0 = 0; wr_base1 = 1; wdata = b1; tick();
        wr_base1 = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        lane0_sum = 32'h11111111; lane1_sum = 32'h22222222;
        #12;
        // R1: reset state
        check("R1 res0", res0, 0);
        check("R1 res1", res1, 0);
        check("R1 base0", base0, 0);
        check("R1 base1", base1, 0);
        @(negedge clk); rst_n = 1;
        lane0_sum = '0; lane1_sum = '0;
        #1;
        check("R1 base0 after release", base0, 0);

        // R2: individual base loads
        set_bases(32'hDEADBEEF, 32'h01234567);
        check("R2 base0", base0, 32'hDEADBEEF);
        check("R2 base1", base1, 32'h01234567);

        // R4/R5 table walk; upper lane1_sm bits nonzero to show they are ignored
        for (int k = 0; k < NV; k++) begin
            blend_en = 0;
            set_bases(VECS[k].b0, VECS[k].b1);
            blend_en = 1; sgn1 = VECS[k].sgn;
            lane1_sm = {24'hA5C3F1, VECS[k].frac};
            tick();
            check(VECS[k].sgn ? "R5 signed blend" : "R4 blend", res1, VECS[k].expv);
        end

        // R3: paired write, unsigned then signed extension, blend at f=128
        lane1_sm = 32'd128; sgn0 = 0; sgn1 = 0;
        wr_pair = 1; wdata = 32'h30005000; tick(); wr_pair = 0;
        check("R3 pair base0 zero-ext", base0, 32'h00005000);
        check("R3 pair base1 zero-ext", base1, 32'h00003000);
        tick();
        check("R4 blend after pair write", res1, 32'h00004000);
        wr_pair = 1; wdata = 32'hE000F000; tick(); wr_pair = 0;
        tick();
        check("R4 unsigned pair blend", res1, 32'h0000E800);
        sgn0 = 1; sgn1 = 1;
        wr_pair = 1; wdata = 32'hE000F000; tick(); wr_pair = 0;
        check("R3 pair base0 sign-ext", base0, 32'hFFFFF000);
        check("R3 pair base1 sign-ext", base1, 32'hFFFFE000);
        tick();
        check("R5 signed pair blend", res1, 32'hFFFFE800);
        // R3: pair overrides individual writes
        sgn0 = 0; sgn1 = 0;
        wr_pair = 1; wr_base0 = 1; wr_base1 = 1; wdata = 32'h00070009; tick();
        wr_pair = 0; wr_base0 = 0; wr_base1 = 0;
        check("R3 pair priority base0", base0, 32'd9);
        check("R3 pair priority base1", base1, 32'd7);

        // R6: blend off passes lane1_sum
        blend_en = 0; lane1_sum = 32'hCAFEF00D; tick();
        check("R6 pass lane1", res1, 32'hCAFEF00D);

        // R9: base write in same cycle as blend uses old base
        set_bases(32'd100, 32'd200);
        blend_en = 1; lane1_sm = 32'd0;
        wr_base0 = 1; wdata = 32'd777; tick(); wr_base0 = 0;
        check("R9 old base used", res1, 32'd100);
        tick();
        check("R9 new base next cycle", res1, 32'd777);
        blend_en = 0;

        // R7: signed clamp sweep to window 0..255
        set_bases(32'd0, 32'd255);
        clamp_en = 1; sgn0 = 1;
        for (int i = -1024; i <= 1024; i += 256) begin
            int v, e;
            v = i >>> 2;
            e = (v < 0) ? 0 : ((v > 255) ? 255 : v);
            lane0_sm = v; tick();
            check("R7 signed clamp sweep", res0, e);
        end
        // R7: unsigned compare treats 0xFFFFFFF0 as large
        set_bases(32'd10, 32'd20);
        sgn0 = 0; lane0_sm = 32'hFFFFFFF0; tick();
        check("R7 unsigned high", res0, 32'd20);
        sgn0 = 1; tick();
        check("R7 signed low", res0, 32'd10);
        // R7: floor test has priority when window is inverted
        set_bases(32'd50, 32'd40);
        sgn0 = 0; lane0_sm = 32'd45; tick();
        check("R7 floor priority", res0, 32'd50);
        lane0_sm = 32'd60; tick();
        check("R7 ceiling", res0, 32'd40);

        // R8: clamp off passes lane0_sum even with blend on
        clamp_en = 0; blend_en = 1; lane0_sum = 32'h0BADC0DE; tick();
        check("R8 pass lane0", res0, 32'h0BADC0DE);

        finish_run();
    end
endmodule